// File: doc/BRIEF.md
# Receive Ring Page Pointer Manager

This block keeps track of a circular receive buffer that lives in local packet memory and is divided into 256-byte pages. It holds two page registers. The boundary register trails one page behind the oldest unread frame. The current-page register marks where the frame writer will put its next frame. From these two registers the block finds the page of the next unread frame and tells the host whether the ring holds anything.

When the host asks for a frame, the block first checks the pointers. If they are good, it reads the 4-byte header at the start of that page from memory. It then checks the header's next-page field against the ring limits, reports the payload length, and places its byte address on the first payload byte. Each payload read strobe moves the byte address forward by one. When the address runs off the top of the ring, it folds back to the bottom. When the host releases the frame, the boundary moves to the page just before the next frame.

The host can also write the boundary register directly. The frame writer loads the current-page register. Writing frames into memory is handled elsewhere, and so is the line interface.

Top module: `rxr_ring_mgr`

## Requirements
- R1: After reset the boundary is START_PG, the current page is START_PG+1, ring_empty is 1, and frm_valid, frm_done and mem_rd are 0.
- R2: The read page is boundary+1, replaced by START_PG when that value is at or above STOP_PG. A fetch reads exactly four bytes, at read_page*256 + 0, 1, 2 and 3, in that order.
- R3: ring_empty is 1 whenever the read page equals the current page. A dequeue on an empty ring does no memory read and gives frm_done with frm_valid 0 and frm_len 0.
- R4: A dequeue on a non-empty ring with the boundary outside [START_PG, STOP_PG) does no memory read. It sets the boundary to START_PG and the current page to START_PG+1, and gives frm_done with frm_valid 0 and frm_len 0.
- R5: Header byte 0 is status and is ignored. Byte 1 is the next page, byte 2 is the length low byte and byte 3 is the length high byte. A good header gives frm_done with frm_valid 1 and frm_len equal to the header length minus 4. frm_valid then stays 1 until release.
- R6: A header whose next page lies outside [START_PG, STOP_PG) gives frm_done with frm_valid 0 and frm_len 0. No frame is held.
- R7: After a good header, mem_addr equals read_page*256+4. Each cycle with pay_rd high while a frame is held raises mem_rd and advances mem_addr by one.
- R8: When the payload address reaches STOP_PG*256 it is reduced by (STOP_PG-START_PG)*256, so byte STOP_PG*256-1 is followed by START_PG*256.
- R9: A release of a held frame sets the boundary to next_page-1, or to STOP_PG-1 when next_page-1 falls below START_PG. It also clears frm_valid.
- R10: A release with no frame held leaves the boundary unchanged. A dequeue while a frame is held gives no frm_done and leaves frm_valid and frm_len unchanged. pay_rd with no frame held leaves mem_rd at 0 and mem_addr unchanged.
- R11: bnry_load writes bnry_in into the boundary and cur_load writes cur_in into the current page. Both show on bnry_page and curr_page one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deq_req | input | 1 | Host asks for the next frame |
| pay_rd | input | 1 | Host reads one payload byte at mem_addr |
| rel | input | 1 | Host releases the held frame |
| cur_load | input | 1 | Frame writer loads the current page |
| cur_in | input | PAGE_W | New current page value |
| bnry_load | input | 1 | Host writes the boundary |
| bnry_in | input | PAGE_W | New boundary value |
| mem_rdata | input | 8 | Read data from packet memory |
| mem_rvalid | input | 1 | mem_rdata is valid (one cycle after mem_rd) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | PAGE_W+8 | Memory byte address |
| frm_done | output | 1 | One-cycle pulse that closes a dequeue |
| frm_valid | output | 1 | A frame is held and frm_len is valid |
| frm_len | output | 16 | Payload length in bytes |
| ring_empty | output | 1 | Read page equals current page |
| bnry_page | output | PAGE_W | Boundary register |
| curr_page | output | PAGE_W | Current-page register |

## Verification
The bench steps the boundary through every page of the ring. For each one it builds a header with a varying next page and length. It then checks the four header addresses, the reported length, the payload start address and the boundary left by the release. A design that failed to wrap the read page at the top of the ring would fetch from page STOP_PG instead of START_PG. A design that got the release wrap wrong would leave the boundary at START_PG-1, outside the ring.

The bench also walks a payload across the top of the ring. A missing wrap there shows up as mem_addr reaching STOP_PG*256. Out-of-range boundaries and next-page fields are placed in the ring. A design that skipped either check would report a bogus length, or would leave the pointers unrepaired. The ignored strobes are checked at the boundary, mem_rd and mem_addr outputs.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_FETCH} ctl_state_t;
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned LEN_W = 16;
endpackage

// File: rtl/rxr_ptr_regs.sv
module rxr_ptr_regs #(
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned START_PG = 'h46,
  parameter int unsigned STOP_PG  = 'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_bnry_we,
  input  logic [PAGE_W-1:0] host_bnry,
  input  logic              host_curr_we,
  input  logic [PAGE_W-1:0] host_curr,
  input  logic              rel_we,
  input  logic [PAGE_W-1:0] rel_bnry,
  input  logic              init_we,
  output logic [PAGE_W-1:0] bnry,
  output logic [PAGE_W-1:0] curr,
  output logic [PAGE_W-1:0] rd_page,
  output logic              bnry_ok,
  output logic              rd_eq_curr,
  output logic              empty
);
  localparam logic [PAGE_W-1:0] START_P  = START_PG[PAGE_W-1:0];
  localparam logic [PAGE_W-1:0] STOP_P   = STOP_PG[PAGE_W-1:0];
  localparam logic [PAGE_W:0]   STOP_X   = STOP_PG[PAGE_W:0];
  localparam logic [PAGE_W-1:0] START_P1 = START_P + 1'b1;

  logic [PAGE_W:0] bnry_inc;

  always_comb begin
    bnry_inc = {1'b0, bnry} + 1'b1;
    if (bnry_inc >= STOP_X) rd_page = START_P;
    else                    rd_page = bnry_inc[PAGE_W-1:0];
    bnry_ok    = (bnry >= START_P) && (bnry < STOP_P);
    rd_eq_curr = (rd_page == curr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bnry  <= START_P;
      curr  <= START_P1;
      empty <= 1'b1;
    end else begin
      if (init_we) begin
        bnry <= START_P;
        curr <= START_P1;
      end else begin
        if (rel_we)            bnry <= rel_bnry;
        else if (host_bnry_we) bnry <= host_bnry;
        if (host_curr_we)      curr <= host_curr;
      end
      empty <= rd_eq_curr;
    end
  end
endmodule

// File: rtl/rxr_hdr_fetch.sv
module rxr_hdr_fetch #(
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned ADDR_W = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PAGE_W-1:0] base_page,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic [7:0]        hdr_next,
  output logic [15:0]       hdr_len
);
  import rxr_pkg::*;

  logic [2:0]        issued;
  logic [1:0]        got;
  logic              active;
  logic [PAGE_W-1:0] base_q;
  logic [7:0]        hb [HDR_BYTES];

  always_comb begin
    rd_en    = active && (issued < 3'(HDR_BYTES));
    rd_addr  = {base_q, 5'd0, issued};
    hdr_next = hb[1];
    hdr_len  = {hb[3], hb[2]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      issued <= '0;
      got    <= '0;
      done   <= 1'b0;
      base_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        issued <= '0;
        got    <= '0;
        base_q <= base_page;
      end else if (active) begin
        if (rd_en) issued <= issued + 1'b1;
        if (mem_rvalid) begin
          got <= got + 1'b1;
          if (got == 2'(HDR_BYTES - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (active && mem_rvalid) hb[got] <= mem_rdata;
  end
endmodule

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen #(
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned START_PG = 'h46,
  parameter int unsigned STOP_PG  = 'h60,
  localparam int unsigned ADDR_W  = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_page,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr
);
  import rxr_pkg::*;

  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(STOP_PG) << 8;
  localparam logic [ADDR_W-1:0] RING_A = ADDR_W'(STOP_PG - START_PG) << 8;

  logic [ADDR_W-1:0] nxt;

  always_comb begin
    nxt = addr + 1'b1;
    if (nxt >= END_A) nxt = nxt - RING_A;
  end

  always_ff @(posedge clk) begin
    if (rst)       addr <= END_A - RING_A;
    else if (load) addr <= {load_page, 8'(HDR_BYTES)};
    else if (adv)  addr <= nxt;
  end
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr #(
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned START_PG = 'h46,
  parameter int unsigned STOP_PG  = 'h60,
  localparam int unsigned ADDR_W  = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              deq_req,
  input  logic              pay_rd,
  input  logic              rel,
  input  logic              cur_load,
  input  logic [PAGE_W-1:0] cur_in,
  input  logic              bnry_load,
  input  logic [PAGE_W-1:0] bnry_in,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_rvalid,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              frm_done,
  output logic              frm_valid,
  output logic [15:0]       frm_len,
  output logic              ring_empty,
  output logic [PAGE_W-1:0] bnry_page,
  output logic [PAGE_W-1:0] curr_page
);
  import rxr_pkg::*;

  localparam logic [PAGE_W-1:0] START_P = START_PG[PAGE_W-1:0];
  localparam logic [PAGE_W-1:0] STOP_P  = STOP_PG[PAGE_W-1:0];

  ctl_state_t        state;
  logic              hold;
  logic [PAGE_W-1:0] nxt_pg;
  logic [PAGE_W-1:0] fetch_pg;
  logic [PAGE_W-1:0] rd_page;
  logic              bnry_ok;
  logic              rd_eq_curr;
  logic              deq_ok, hdr_start, init_we, rel_ok, adv, next_ok;
  logic [PAGE_W-1:0] rel_bnry;
  logic              hdr_rd, hdr_done;
  logic [ADDR_W-1:0] hdr_addr, pay_addr;
  logic [7:0]        hdr_next;
  logic [15:0]       hdr_len;

  always_comb begin
    deq_ok    = deq_req && (state == ST_IDLE) && !hold;
    hdr_start = deq_ok && !rd_eq_curr && bnry_ok;
    init_we   = deq_ok && !rd_eq_curr && !bnry_ok;
    rel_ok    = rel && hold;
    adv       = pay_rd && hold;
    next_ok   = (hdr_next[PAGE_W-1:0] >= START_P) && (hdr_next[PAGE_W-1:0] < STOP_P);
    rel_bnry  = (nxt_pg <= START_P) ? (STOP_P - 1'b1) : (nxt_pg - 1'b1);
    mem_rd    = hdr_rd | adv;
    mem_addr  = (state == ST_FETCH) ? hdr_addr : pay_addr;
  end

  rxr_ptr_regs #(.PAGE_W(PAGE_W), .START_PG(START_PG), .STOP_PG(STOP_PG)) ptr_i (
    .clk(clk), .rst(rst),
    .host_bnry_we(bnry_load), .host_bnry(bnry_in),
    .host_curr_we(cur_load), .host_curr(cur_in),
    .rel_we(rel_ok), .rel_bnry(rel_bnry),
    .init_we(init_we),
    .bnry(bnry_page), .curr(curr_page), .rd_page(rd_page),
    .bnry_ok(bnry_ok), .rd_eq_curr(rd_eq_curr), .empty(ring_empty)
  );

  rxr_hdr_fetch #(.PAGE_W(PAGE_W)) hdr_i (
    .clk(clk), .rst(rst), .start(hdr_start), .base_page(rd_page),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rd_en(hdr_rd), .rd_addr(hdr_addr), .done(hdr_done),
    .hdr_next(hdr_next), .hdr_len(hdr_len)
  );

  rxr_addr_gen #(.PAGE_W(PAGE_W), .START_PG(START_PG), .STOP_PG(STOP_PG)) addr_i (
    .clk(clk), .rst(rst), .load(hdr_done && next_ok), .load_page(fetch_pg),
    .adv(adv), .addr(pay_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hold      <= 1'b0;
      nxt_pg    <= START_P;
      fetch_pg  <= START_P;
      frm_done  <= 1'b0;
      frm_valid <= 1'b0;
      frm_len   <= '0;
    end else begin
      frm_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (deq_ok) begin
            if (hdr_start) begin
              state    <= ST_FETCH;
              fetch_pg <= rd_page;
            end else begin
              frm_done  <= 1'b1;
              frm_valid <= 1'b0;
              frm_len   <= '0;
            end
          end
          if (rel_ok) begin
            hold      <= 1'b0;
            frm_valid <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (hdr_done) begin
            state    <= ST_IDLE;
            frm_done <= 1'b1;
            if (next_ok) begin
              hold      <= 1'b1;
              frm_valid <= 1'b1;
              frm_len   <= hdr_len - 16'(HDR_BYTES);
              nxt_pg    <= hdr_next[PAGE_W-1:0];
            end else begin
              frm_valid <= 1'b0;
              frm_len   <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_ring_mgr_chk.sv
module rxr_ring_mgr_chk #(
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned START_PG = 'h46,
  parameter int unsigned STOP_PG  = 'h60,
  localparam int unsigned ADDR_W  = PAGE_W + 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pay_rd,
  input logic              rel,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              frm_done,
  input logic              frm_valid,
  input logic [15:0]       frm_len,
  input logic [PAGE_W-1:0] bnry_page
);
  localparam logic [ADDR_W-1:0] LAST_A  = (ADDR_W'(STOP_PG) << 8) - 1'b1;
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(START_PG) << 8;
  localparam logic [PAGE_W-1:0] START_P = START_PG[PAGE_W-1:0];
  localparam logic [PAGE_W-1:0] STOP_P  = STOP_PG[PAGE_W-1:0];

  // R8: the top byte of the ring is followed by the bottom byte
  a_r8_addr_wrap: assert property (@(posedge clk) disable iff (rst)
    frm_valid && pay_rd && (mem_addr == LAST_A) |=> (mem_addr == FIRST_A));

  // R7: each payload read moves the address by one
  a_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
    frm_valid && pay_rd && (mem_addr != LAST_A) |=> (mem_addr == $past(mem_addr) + 1'b1));

  // R9: a release always leaves the boundary inside the ring
  a_r9_release_range: assert property (@(posedge clk) disable iff (rst)
    frm_valid && rel |=> (bnry_page >= START_P) && (bnry_page < STOP_P) && !frm_valid);

  // R3: a dequeue without a frame reports no length
  a_r3_no_len: assert property (@(posedge clk) disable iff (rst)
    frm_done && !frm_valid |-> (frm_len == 16'd0));

  // R2: with no frame held, reads touch only the four header offsets
  a_r2_hdr_offsets: assert property (@(posedge clk) disable iff (rst)
    mem_rd && !frm_valid |-> (mem_addr[7:0] < 8'd4));
endmodule

bind rxr_ring_mgr rxr_ring_mgr_chk #(.PAGE_W(PAGE_W), .START_PG(START_PG), .STOP_PG(STOP_PG)) chk_i (
  .clk(clk), .rst(rst), .pay_rd(pay_rd), .rel(rel), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .frm_done(frm_done), .frm_valid(frm_valid), .frm_len(frm_len), .bnry_page(bnry_page)
);

// File: tb/rxr_ring_mgr_tb.sv
`timescale 1ns/1ps
module rxr_ring_mgr_tb_top;
  localparam int START = 'h46;
  localparam int STOP  = 'h60;
  localparam int NPG   = STOP - START;

  logic        clk = 1'b0;
  logic        rst, deq_req, pay_rd, rel, cur_load, bnry_load;
  logic [7:0]  cur_in, bnry_in, mem_rdata;
  logic        mem_rvalid;
  logic        mem_rd, frm_done, frm_valid, ring_empty;
  logic [15:0] mem_addr, frm_len;
  logic [7:0]  bnry_page, curr_page;

  int checks = 0;
  int errors = 0;
  int rd_total = 0;
  int rd_start;
  logic [15:0] rd_log [8];
  logic [7:0]  hnext [256];
  logic [15:0] hlen  [256];

  always #10 clk = ~clk;

  rxr_ring_mgr #(.PAGE_W(8), .START_PG(START), .STOP_PG(STOP)) dut_i (
    .clk(clk), .rst(rst), .deq_req(deq_req), .pay_rd(pay_rd), .rel(rel),
    .cur_load(cur_load), .cur_in(cur_in), .bnry_load(bnry_load), .bnry_in(bnry_in),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .frm_done(frm_done), .frm_valid(frm_valid), .frm_len(frm_len),
    .ring_empty(ring_empty), .bnry_page(bnry_page), .curr_page(curr_page)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    case (a[7:0])
      8'd0: return 8'hA5;
      8'd1: return hnext[a[15:8]];
      8'd2: return hlen[a[15:8]][7:0];
      8'd3: return hlen[a[15:8]][15:8];
      default: return a[7:0] ^ a[15:8];
    endcase
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_rd;
    mem_rdata  <= mem_byte(mem_addr);
    if (mem_rd === 1'b1) begin
      rd_log[rd_total % 8] <= mem_addr;
      rd_total <= rd_total + 1;
    end
  end

  function automatic int rdp(input int b);
    return (b + 1 >= STOP) ? START : b + 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ptrs(input int b, input int c);
    bnry_load = 1'b1; bnry_in = 8'(b); cur_load = 1'b1; cur_in = 8'(c);
    @(negedge clk);
    bnry_load = 1'b0; cur_load = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_deq(output logic got, output logic v, output logic [15:0] l, output int nrd);
    int n;
    rd_start = rd_total;
    deq_req = 1'b1;
    @(negedge clk);
    deq_req = 1'b0;
    n = 0;
    while (frm_done !== 1'b1 && n < 40) begin
      @(negedge clk);
      n++;
    end
    got = frm_done; v = frm_valid; l = frm_len; nrd = rd_total - rd_start;
  endtask

  task automatic do_rel;
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_pay(input int n);
    pay_rd = 1'b1;
    repeat (n) @(negedge clk);
    pay_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic got, v;
    logic [15:0] l;
    int nrd;
    for (int i = 0; i < 256; i++) begin
      hnext[i] = 8'(START);
      hlen[i]  = 16'd64;
    end
    rst = 1'b1; deq_req = 0; pay_rd = 0; rel = 0; cur_load = 0; bnry_load = 0;
    cur_in = 0; bnry_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 bnry", 32'(bnry_page), START);
    chk("R1 curr", 32'(curr_page), START + 1);
    chk("R1 empty", 32'(ring_empty), 1);
    chk("R1 valid", 32'(frm_valid), 0);
    chk("R1 done", 32'(frm_done), 0);
    chk("R1 mem_rd", 32'(mem_rd), 0);

    // sweep every boundary page in the ring
    for (int p = START; p < STOP; p++) begin
      int rd, nx, ex;
      logic [15:0] len;
      rd = rdp(p);
      nx = rd + 1 + (p % 3);
      if (nx >= STOP) nx = nx - NPG;
      len = 16'((p & 3) << 8) + 16'h0010 + 16'(p);
      hnext[rd] = 8'(nx);
      hlen[rd]  = len;
      set_ptrs(p, nx);
      chk("R11 bnry load", 32'(bnry_page), p);
      chk("R11 curr load", 32'(curr_page), nx);
      chk("R3 not empty", 32'(ring_empty), 0);
      do_deq(got, v, l, nrd);
      chk("R5 done", 32'(got), 1);
      chk("R5 valid", 32'(v), 1);
      chk("R5 length", 32'(l), 32'(len) - 4);
      chk("R2 read count", nrd, 4);
      for (int k = 0; k < 4; k++)
        chk("R2 header addr", 32'(rd_log[(rd_start + k) % 8]), rd * 256 + k);
      chk("R7 payload start", 32'(mem_addr), rd * 256 + 4);
      do_rel();
      ex = (nx - 1 < START) ? STOP - 1 : nx - 1;
      chk("R9 release bnry", 32'(bnry_page), ex);
      chk("R9 valid cleared", 32'(frm_valid), 0);
      set_ptrs(ex, rdp(ex));
      chk("R3 empty flag", 32'(ring_empty), 1);
      do_deq(got, v, l, nrd);
      chk("R3 empty done", 32'(got), 1);
      chk("R3 empty valid", 32'(v), 0);
      chk("R3 empty len", 32'(l), 0);
      chk("R3 empty no read", nrd, 0);
    end

    // bad boundary values
    for (int t = 0; t < 2; t++) begin
      int bb;
      bb = (t == 0) ? 'h10 : STOP;
      set_ptrs(bb, 'h50);
      chk("R4 not empty", 32'(ring_empty), 0);
      do_deq(got, v, l, nrd);
      chk("R4 done", 32'(got), 1);
      chk("R4 valid", 32'(v), 0);
      chk("R4 len", 32'(l), 0);
      chk("R4 no read", nrd, 0);
      @(negedge clk);
      chk("R4 bnry reset", 32'(bnry_page), START);
      chk("R4 curr reset", 32'(curr_page), START + 1);
      @(negedge clk);
      chk("R4 empty after", 32'(ring_empty), 1);
    end

    // bad next-page field, then release without a frame
    for (int t = 0; t < 2; t++) begin
      hnext['h51] = (t == 0) ? 8'h20 : 8'(STOP);
      hlen['h51]  = 16'd100;
      set_ptrs('h50, 'h55);
      do_deq(got, v, l, nrd);
      chk("R6 done", 32'(got), 1);
      chk("R6 valid", 32'(v), 0);
      chk("R6 len", 32'(l), 0);
      chk("R6 read count", nrd, 4);
      do_rel();
      chk("R10 rel ignored", 32'(bnry_page), 'h50);
    end
    hnext['h51] = 8'h52;

    // payload walk across the top of the ring
    hnext[STOP - 1] = 8'(START);
    hlen[STOP - 1]  = 16'd600;
    set_ptrs(STOP - 2, START + 3);
    do_deq(got, v, l, nrd);
    chk("R5 top frame valid", 32'(v), 1);
    chk("R5 top frame len", 32'(l), 596);
    chk("R7 top start", 32'(mem_addr), (STOP - 1) * 256 + 4);
    pay_rd = 1'b1;
    @(negedge clk);
    chk("R7 mem_rd on pay", 32'(mem_rd), 1);
    pay_rd = 1'b0;
    do_pay(4);
    chk("R7 step", 32'(mem_addr), (STOP - 1) * 256 + 9);
    do_pay(246);
    chk("R8 last byte", 32'(mem_addr), STOP * 256 - 1);
    do_pay(1);
    chk("R8 wrap", 32'(mem_addr), START * 256);
    do_pay(3);
    chk("R8 after wrap", 32'(mem_addr), START * 256 + 3);
    // dequeue while held
    rd_start = rd_total;
    deq_req = 1'b1;
    @(negedge clk);
    deq_req = 1'b0;
    begin
      int seen;
      seen = 0;
      repeat (10) begin
        if (frm_done === 1'b1) seen = 1;
        @(negedge clk);
      end
      chk("R10 deq held no done", seen, 0);
    end
    chk("R10 deq held valid", 32'(frm_valid), 1);
    chk("R10 deq held len", 32'(frm_len), 596);
    chk("R10 deq held no read", rd_total - rd_start, 0);
    do_rel();
    chk("R9 release wrap", 32'(bnry_page), STOP - 1);
    // payload strobe without a frame
    begin
      logic [15:0] a0;
      a0 = mem_addr;
      pay_rd = 1'b1;
      @(negedge clk);
      chk("R10 pay no frame rd", 32'(mem_rd), 0);
      @(negedge clk);
      pay_rd = 1'b0;
      chk("R10 pay no frame addr", 32'(mem_addr), 32'(a0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule